// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage register that converts a parallel word into a serial bit stream. Stages are called A (first) through H (last). Each shift moves every stage one position toward H, and the serial input enters stage A. Stage H drives a true output and an inverted output, so the word leaves last stage first.

Loading is a level, not an edge. While the active-low load control is low, every stage follows its parallel input bit with no clock involved. Each stage has its own asynchronous set and clear, worked out from its parallel bit and the load control.

Shifting uses a gated clock. It is the OR of two clock pins that can be swapped for each other. Holding either pin high blocks shifting. With load high and one pin low, each rising edge on the other pin performs exactly one shift. The block has no data stream with flow control: every pin is a plain level. So there is no valid/ready handshake and no back-pressure.

Top module: `piso_shreg`

## Requirements
- R1: The register has eight stages. Bit i of `par_in` belongs to stage i, with bit 0 as stage A and bit 7 as stage H. A shift moves bit i into bit i+1. A word holding only stage A set shows a 1 on `q_last` after exactly seven shifts and not before.
- R2: While `load_n` is 0, every stage equals its `par_in` bit. When `par_in` changes during a load, the stages follow it at once, with no clock edge.
- R3: After `load_n` returns to 1, the loaded word is held unchanged until the first qualifying rising clock edge. Changes on `par_in` while `load_n` is 1 have no effect.
- R4: While `load_n` is 1 and `clk_b` is 0, a rising edge on `clk_a` performs one shift. `ser_in` is captured into stage A.
- R5: A rising edge on either clock pin while the other pin is 1 leaves all eight stages unchanged.
- R6: The clock pins are interchangeable. While `load_n` is 1 and `clk_a` is 0, a rising edge on `clk_b` performs the same shift as R4.
- R7: `q_last` equals stage H and `q_last_n` equals its complement at all times. Changing `ser_in` without a clock edge changes neither output.
- R8: After a load and its release, eight qualifying shifts present `par_in` bits 7, 6, 5, 4, 3, 2, 1, 0 on `q_last`, one per shift period.
- R9: Clock edges while `load_n` is 0 have no effect. On release, the register holds `par_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| load_n | input | 1 | Active-low level load; stages follow `par_in` while 0 |
| clk_a | input | 1 | Clock pin; its rising edge shifts while `clk_b` is 0 |
| clk_b | input | 1 | Clock pin; its rising edge shifts while `clk_a` is 0 |
| ser_in | input | 1 | Serial bit captured into stage A on each shift |
| par_in | input | 8 | Parallel word; bit 0 goes to stage A, bit 7 to stage H |
| q_last | output | 1 | Stage H value |
| q_last_n | output | 1 | Complement of stage H |

## Verification
Three properties are checked at every gated-clock edge and every load release:
- each stage holds its parallel bit when load is released;
- the first edge after a load still sees the captured word;
- every other edge sees the previous contents shifted one place, with the serial bit in stage A.

Other behaviours appear only in the bench scenarios, run against a bit-accurate model of the pins. These are: inhibit by a held-high clock pin, use of the second clock pin, load pulses between edges, clock activity during a load, and the full serial order of a loaded word.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  localparam int unsigned DEF_STAGES = 8;
endpackage

// File: rtl/piso_clk_gate.sv
`timescale 1ns/1ps
module piso_clk_gate (
  input  logic clk_a,
  input  logic clk_b,
  output logic gclk
);
  // A rising edge appears on gclk only when one pin rises while the other is low.
  assign gclk = clk_a | clk_b;
endmodule

// File: rtl/piso_stage.sv
`timescale 1ns/1ps
module piso_stage (
  input  logic shift_clk,
  input  logic load_n,
  input  logic preset_val,
  input  logic shift_in,
  output logic bit_q
);
  logic set_n;
  logic clr_n;

  // Level load: exactly one of set/clear is active while load_n is low.
  assign set_n = ~(~load_n & preset_val);
  assign clr_n = ~(~load_n & ~preset_val);

  always_ff @(posedge shift_clk or negedge set_n or negedge clr_n) begin
    if (!set_n)      bit_q <= 1'b1;
    else if (!clr_n) bit_q <= 1'b0;
    else             bit_q <= shift_in;
  end

  // R2: at load release the stage holds its parallel bit
  a_r2_stage_tracks: assert property (@(posedge load_n) bit_q == preset_val);
endmodule

// File: rtl/piso_shreg.sv
`timescale 1ns/1ps
module piso_shreg #(
  parameter int unsigned STAGES = piso_pkg::DEF_STAGES
) (
  input  logic              load_n,
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              q_last,
  output logic              q_last_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic              gclk;
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  piso_clk_gate u_gate (.clk_a(clk_a), .clk_b(clk_b), .gclk(gclk));

  assign stage_d = {stage_q[LAST-1:0], ser_in};

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    piso_stage u_stage (
      .shift_clk (gclk),
      .load_n    (load_n),
      .preset_val(par_in[gi]),
      .shift_in  (stage_d[gi]),
      .bit_q     (stage_q[gi])
    );
  end

  assign q_last   = stage_q[LAST];
  assign q_last_n = ~stage_q[LAST];

  // Checker state: whether a load occurred since the last gated edge, and the word it left.
  logic              reloaded;
  logic [STAGES-1:0] load_cap;

  always_ff @(posedge gclk or negedge load_n) begin
    if (!load_n) reloaded <= 1'b1;
    else         reloaded <= 1'b0;
  end

  always_ff @(posedge load_n) load_cap <= par_in;

  // R3: first edge after a load still sees the loaded word
  a_r3_hold_after_load: assert property (@(posedge gclk) disable iff (!load_n)
    reloaded |-> (stage_q == load_cap));

  // R4: consecutive edges with no load in between show a one-place shift
  a_r4_shift_step: assert property (@(posedge gclk) disable iff (!load_n)
    !reloaded |-> (stage_q[LAST:1] == $past(stage_q[LAST-1:0]) && stage_q[0] == $past(ser_in)));

  // R7: outputs at release reflect the top parallel bit
  a_r7_out_at_release: assert property (@(posedge load_n)
    (q_last == par_in[LAST]) && (q_last_n == ~par_in[LAST]));
endmodule

// File: tb/piso_shreg_bench.sv
`timescale 1ns/1ps
module piso_shreg_bench;
  logic bclk = 1'b0;
  always #2.5 bclk = ~bclk;

  logic       load_n = 1'b0, clk_a = 1'b0, clk_b = 1'b0, ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       q_last, q_last_n;

  piso_shreg u_piso_shreg (
    .load_n(load_n), .clk_a(clk_a), .clk_b(clk_b), .ser_in(ser_in),
    .par_in(par_in), .q_last(q_last), .q_last_n(q_last_n)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Planned input levels and reference model
  logic       ld = 1'b0, ca = 1'b0, cb = 1'b0, si = 1'b0;
  logic [7:0] par = 8'h00;
  logic [7:0] m = 8'h00;
  logic       pa = 1'b0, pb = 1'b0;

  string      tag_q[$];
  logic [1:0] exp_q[$];

  task automatic drive(input string tag);
    logic og, ng;
    @(posedge bclk); #1;
    og = pa | pb;
    ng = ca | cb;
    load_n = ld; clk_a = ca; clk_b = cb; ser_in = si; par_in = par;
    if (!ld) m = par;
    else if (!og && ng) m = {m[6:0], si};
    pa = ca; pb = cb;
    tag_q.push_back(tag);
    exp_q.push_back({m[7], ~m[7]});
  endtask

  task automatic do_load(input logic [7:0] p);
    ld = 1'b0; par = p; drive("R2");
  endtask

  task automatic do_release();
    ld = 1'b1; drive("R3");
  endtask

  task automatic pulse_a(input string tag);
    ca = 1'b1; drive(tag);
    ca = 1'b0; drive(tag);
  endtask

  task automatic pulse_b(input string tag);
    cb = 1'b1; drive(tag);
    cb = 1'b0; drive(tag);
  endtask

  // Monitor: pops expected items and compares away from the driving instant
  initial begin
    forever begin
      @(negedge bclk);
      while (exp_q.size() > 0) begin
        string      t;
        logic [1:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        tests++;
        if ({q_last, q_last_n} !== e) begin
          fails++;
          $display("FAIL %s: outputs=%b expected=%b", t, {q_last, q_last_n}, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R2: level load follows parallel changes
    do_load(8'hA5);
    do_load(8'h3C);
    do_load(8'hC3);
    // R9: clock edges during a load do nothing
    pulse_a("R9");
    pulse_b("R9");
    do_release();
    // R3: hold until edge; parallel changes ignored
    par = 8'h00; drive("R3");
    par = 8'h7E; drive("R3");
    // R7: serial changes alone do not move outputs
    si = 1'b1; drive("R7");
    si = 1'b0; drive("R7");
    // R8: serial order H..A of C3 via clk_a
    for (int i = 0; i < 8; i++) pulse_a("R8");

    // R1: single stage A bit reaches output after seven shifts
    do_load(8'h01); do_release();
    si = 1'b0; drive("R1");
    for (int i = 0; i < 8; i++) pulse_a("R1");

    // R6: shifting with clk_b, alternating serial input
    do_load(8'h96); do_release();
    for (int i = 0; i < 10; i++) begin
      si = i[0]; drive("R6");
      pulse_b("R6");
    end

    // R4: serial capture into stage A seen after eight shifts
    do_load(8'h00); do_release();
    for (int i = 0; i < 16; i++) begin
      si = (i % 3 == 0); drive("R4");
      pulse_a("R4");
    end

    // R5: inhibit with the other pin held high
    do_load(8'h5A); do_release();
    cb = 1'b1; drive("R5");
    pulse_a("R5"); pulse_a("R5");
    cb = 1'b0; drive("R5");
    ca = 1'b1; drive("R5");
    pulse_b("R5");
    ca = 1'b0; drive("R5");
    for (int i = 0; i < 8; i++) pulse_b("R5");

    // R3: load pulse between edges while a clock pin is high
    ca = 1'b1; drive("R3");
    do_load(8'hE1); do_release();
    ca = 1'b0; drive("R3");
    for (int i = 0; i < 8; i++) pulse_a("R8");

    // Random mix against the model
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 5);
      case (r)
        0: begin si = ~si; drive("R7"); end
        1: begin ca = ~ca; drive(!ld ? "R9" : (ca && cb) ? "R5" : (ca && !cb) ? "R4" : "R4"); end
        2: begin cb = ~cb; drive(!ld ? "R9" : (cb && ca) ? "R5" : (cb && !ca) ? "R6" : "R6"); end
        3: begin ld = 1'b0; par = 8'($urandom); drive("R2"); end
        4: begin ld = 1'b1; drive("R3"); end
        default: begin par = 8'($urandom); drive(ld ? "R3" : "R2"); end
      endcase
    end

    @(posedge bclk);
    @(posedge bclk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule